// File: doc/BRIEF.md
# Two-Stage Cascaded Priority Interrupt Controller

This block collects fifteen level-sensitive interrupt request lines into two eight-input stages, a primary and a secondary. The secondary stage feeds primary input 2. The block picks the highest-priority live request across both stages and raises one interrupt line toward the processor. A one-cycle acknowledge strobe makes the block return a vector byte for the winning line and mark that line as in service. Each stage has its own base vector, mask register and in-service register. Each stage also accepts a non-specific end-of-interrupt command, which retires the most urgent line in service on that stage.

Requests are sampled, not latched. A request that goes away before it is acknowledged leaves no trace. If an acknowledge arrives when no request survives, the block returns the vector of the last input of the stage involved and flags the result as a lost interrupt. Software programs the block and sends end-of-interrupt commands through a small write port.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, irq_o, vec_o and lost_o are 0, both masks are clear and no line is in service.
- R2: Priority from highest to lowest is line 0, line 1, lines 8..15 in ascending order, then lines 3..7 in ascending order. An acknowledge returns the vector of the highest-priority line that is pending and not masked.
- R3: Line 2 has no request of its own. A request on req_i[2] is treated as a request on line 9.
- R4: The vector is {base[7:3], index}. The index is the input number 0..7 within the stage. The base comes from the primary register (address 0) for lines 0..7 and from the secondary register (address 2) for lines 8..15. The low three base bits are ignored.
- R5: irq_o is high only while cpu_ie_i is high. A request that is raised and dropped while cpu_ie_i is low causes no interrupt once cpu_ie_i returns high.
- R6: An acknowledge marks the winning line as in service. A line at or below the highest-priority in-service line of its stage cannot raise irq_o, but a higher-priority line can. A secondary line in service also holds primary input 2 in service.
- R7: A lower-priority request that is raised and then dropped while a higher line waits for its end-of-interrupt causes no interrupt after that end-of-interrupt.
- R8: A write to address 4 (primary) or address 5 (secondary) is a non-specific end-of-interrupt. It clears only the highest-priority in-service bit of that stage and ignores the write data.
- R9: An acknowledge with no qualifying request returns {primary base[7:3], 7}. If the secondary request vanished while the cascade input was still seen, it returns {secondary base[7:3], 7} instead. Either case sets lost_o and marks no line in service.
- R10: A mask write (address 1 primary, address 3 secondary, bit n masks input n) takes effect on the clock edge that captures it. A masked line neither raises irq_o nor wins an acknowledge.
- R11: lost_o is 0 after any acknowledge that returns a real line's vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Level request per line; bit 2 aliases line 9 |
| cpu_ie_i | input | 1 | Processor interrupt-enable flag |
| inta_i | input | 1 | Acknowledge strobe, one cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | 0/2 base, 1/3 mask, 4/5 end-of-interrupt |
| wr_data_i | input | 8 | Write data |
| irq_o | output | 1 | Interrupt request to processor |
| vec_o | output | 8 | Vector from the last acknowledge |
| lost_o | output | 1 | Last acknowledge found no live request |

## Verification
The priority table applies single requests, pairs of requests that straddle the stage boundary, the whole primary group and every line at once. These patterns separate a correct priority order from one that is plain index order or that puts the secondary stage last. A request on line 2 alone shows the alias to line 9. Directed sequences nest acknowledges on lines 3 and 1 and then place a secondary request between them. Whether that request is blocked or passed after one end-of-interrupt shows which in-service bit was cleared. Short request pulses while interrupts are disabled, or while a higher line is in service, show that requests are not latched. Lost acknowledges are forced on both stages and then followed by a live request, which shows that no in-service bit was left behind.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int STAGE_N = 8;
  localparam int IDX_W   = $clog2(STAGE_N);
  localparam int VEC_W   = 8;
  localparam int LINES   = 2 * STAGE_N;
  localparam int CASC_IN = 2;
  localparam int ALIAS_IN = 1;

  typedef enum logic [2:0] {
    A_PRI_BASE = 3'd0,
    A_PRI_MASK = 3'd1,
    A_SEC_BASE = 3'd2,
    A_SEC_MASK = 3'd3,
    A_PRI_EOI  = 3'd4,
    A_SEC_EOI  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/pic_prio_res.sv
module pic_prio_res #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  isr_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic          top_isr_valid_o,
  output logic [IW-1:0] top_isr_idx_o
);
  // lowest index wins; any in-service bit at or above a request blocks it
  always_comb begin
    logic blocked;
    blocked = 1'b0;
    valid_o = 1'b0;
    idx_o   = '0;
    top_isr_valid_o = 1'b0;
    top_isr_idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (isr_i[i] && !top_isr_valid_o) begin
        top_isr_valid_o = 1'b1;
        top_isr_idx_o   = IW'(i);
      end
      blocked = blocked | isr_i[i];
      if (pend_i[i] && !blocked && !valid_o) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_stage.sv
module pic_stage #(
  parameter int N  = 8,
  parameter int IW = $clog2(N),
  parameter int VW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_we_i,
  input  logic          mask_we_i,
  input  logic          eoi_i,
  input  logic [VW-1:0] wdata_i,
  input  logic [N-1:0]  raw_i,
  input  logic          ack_i,
  input  logic [IW-1:0] ack_idx_i,
  output logic          cand_valid_o,
  output logic [IW-1:0] cand_idx_o,
  output logic [VW-1:0] base_o,
  output logic [N-1:0]  isr_o
);
  logic [N-1:0]  mask_q, isr_q, isr_d, pend;
  logic [VW-1:0] base_q;
  logic          top_v;
  logic [IW-1:0] top_idx;

  assign pend = raw_i & ~mask_q;

  pic_prio_res #(.N(N), .IW(IW)) u_res (
    .pend_i(pend), .isr_i(isr_q),
    .valid_o(cand_valid_o), .idx_o(cand_idx_o),
    .top_isr_valid_o(top_v), .top_isr_idx_o(top_idx)
  );

  always_comb begin
    isr_d = isr_q;
    if (eoi_i && top_v) isr_d[top_idx] = 1'b0;
    if (ack_i)          isr_d[ack_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      base_q <= '0;
      isr_q  <= '0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i[N-1:0];
      if (base_we_i) base_q <= wdata_i;
      isr_q <= isr_d;
    end
  end

  assign base_o = base_q;
  assign isr_o  = isr_q;

  AST_MASKED_NEVER_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_o |-> !mask_q[cand_idx_o]); // R10
  AST_CAND_NOT_IN_SERVICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_o |-> !isr_q[cand_idx_o]); // R6
  AST_ACK_MARKS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> isr_q[$past(ack_idx_i)]); // R6
  AST_EOI_DROPS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && isr_q != '0) |=> $countones(isr_q) == $countones($past(isr_q)) - 1); // R8
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import pic_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] req_i,
  input  logic             cpu_ie_i,
  input  logic             inta_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [VEC_W-1:0] wr_data_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             lost_o
);
  logic [LINES-1:0]   irr_q, req_eff;
  logic               casc_q;
  logic [STAGE_N-1:0] pri_raw, pri_isr, sec_isr;
  logic               pri_v, sec_v, pri_ack, sec_ack;
  logic [IDX_W-1:0]   pri_idx, sec_idx;
  logic [VEC_W-1:0]   pri_base, sec_base, vec_q;
  logic               lost_q;

  // line 2 is the cascade input; its pin folds onto line 9
  always_comb begin
    req_eff = req_i;
    req_eff[CASC_IN] = 1'b0;
    req_eff[STAGE_N + ALIAS_IN] = req_i[STAGE_N + ALIAS_IN] | req_i[CASC_IN];
  end

  always_comb begin
    pri_raw = irr_q[STAGE_N-1:0];
    pri_raw[CASC_IN] = casc_q;
  end

  wire is_wr_pb = wr_en_i && (wr_addr_i == A_PRI_BASE);
  wire is_wr_pm = wr_en_i && (wr_addr_i == A_PRI_MASK);
  wire is_wr_sb = wr_en_i && (wr_addr_i == A_SEC_BASE);
  wire is_wr_sm = wr_en_i && (wr_addr_i == A_SEC_MASK);
  wire is_eoi_p = wr_en_i && (wr_addr_i == A_PRI_EOI);
  wire is_eoi_s = wr_en_i && (wr_addr_i == A_SEC_EOI);

  wire pri_is_casc = (pri_idx == IDX_W'(CASC_IN));
  assign pri_ack = inta_i && pri_v && (!pri_is_casc || sec_v);
  assign sec_ack = inta_i && pri_v && pri_is_casc && sec_v;

  pic_stage #(.N(STAGE_N), .IW(IDX_W), .VW(VEC_W)) u_pri (
    .clk_i, .rst_ni,
    .base_we_i(is_wr_pb), .mask_we_i(is_wr_pm), .eoi_i(is_eoi_p),
    .wdata_i(wr_data_i), .raw_i(pri_raw),
    .ack_i(pri_ack), .ack_idx_i(pri_idx),
    .cand_valid_o(pri_v), .cand_idx_o(pri_idx),
    .base_o(pri_base), .isr_o(pri_isr)
  );

  pic_stage #(.N(STAGE_N), .IW(IDX_W), .VW(VEC_W)) u_sec (
    .clk_i, .rst_ni,
    .base_we_i(is_wr_sb), .mask_we_i(is_wr_sm), .eoi_i(is_eoi_s),
    .wdata_i(wr_data_i), .raw_i(irr_q[LINES-1:STAGE_N]),
    .ack_i(sec_ack), .ack_idx_i(sec_idx),
    .cand_valid_o(sec_v), .cand_idx_o(sec_idx),
    .base_o(sec_base), .isr_o(sec_isr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      casc_q <= 1'b0;
      vec_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      irr_q  <= req_eff;
      casc_q <= sec_v;
      if (inta_i) begin
        if (!pri_v) begin
          vec_q  <= {pri_base[VEC_W-1:IDX_W], {IDX_W{1'b1}}};
          lost_q <= 1'b1;
        end else if (!pri_is_casc) begin
          vec_q  <= {pri_base[VEC_W-1:IDX_W], pri_idx};
          lost_q <= 1'b0;
        end else if (sec_v) begin
          vec_q  <= {sec_base[VEC_W-1:IDX_W], sec_idx};
          lost_q <= 1'b0;
        end else begin
          vec_q  <= {sec_base[VEC_W-1:IDX_W], {IDX_W{1'b1}}};
          lost_q <= 1'b1;
        end
      end
    end
  end

  assign irq_o  = pri_v && cpu_ie_i;
  assign vec_o  = vec_q;
  assign lost_o = lost_q;

  AST_LOST_IS_LAST_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_q |-> vec_q[IDX_W-1:0] == {IDX_W{1'b1}}); // R9
  AST_SEC_HOLDS_CASCADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_isr != '0) |-> pri_isr[CASC_IN]); // R6
  AST_LOST_MARKS_NOTHING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !pri_ack && !is_eoi_p) |=> $stable(pri_isr)); // R9
endmodule

// File: tb/cascade_irq_ctrl_tb_top.sv
module cascade_irq_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] req_i = '0;
  logic        cpu_ie_i = 1'b0;
  logic        inta_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        irq_o, lost_o;
  logic [7:0]  vec_o;
  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  cascade_irq_ctrl dut_i (.*);

  // {request pattern, expected winning line}
  localparam logic [19:0] TBL [10] = '{
    {16'h0003, 4'd0}, {16'h0102, 4'd1}, {16'h0108, 4'd8}, {16'h8008, 4'd15},
    {16'h00F8, 4'd3}, {16'h00C0, 4'd6}, {16'h0004, 4'd9}, {16'h0600, 4'd9},
    {16'hFFFB, 4'd0}, {16'h0080, 4'd7}
  };

  task automatic tick(); @(posedge clk_i); @(negedge clk_i); endtask
  task automatic wait3(); repeat (3) tick(); endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic ack();
    inta_i = 1'b1; tick(); inta_i = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] vec_of(input int line);
    return (line < 8) ? (8'h20 | 8'(line)) : (8'h70 | 8'(line - 8));
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 irq", {7'd0, irq_o}, 8'd0);
    chk("R1 vec", vec_o, 8'd0);
    chk("R1 lost", {7'd0, lost_o}, 8'd0);
    rst_ni = 1'b1;
    tick();
    wr(3'd0, 8'h25);   // low bits must be ignored (R4)
    wr(3'd2, 8'h70);
    cpu_ie_i = 1'b1;

    // priority table: R2, R3, R4, R11, R8
    for (int k = 0; k < 10; k++) begin
      int line;
      req_i = TBL[k][19:4];
      line = int'(TBL[k][3:0]);
      wait3();
      chk($sformatf("R2 irq row %0d", k), {7'd0, irq_o}, 8'd1);
      ack();
      chk($sformatf("R2 R3 R4 vec row %0d", k), vec_o, vec_of(line));
      chk($sformatf("R11 lost row %0d", k), {7'd0, lost_o}, 8'd0);
      req_i = '0;
      if (line >= 8) wr(3'd5, 8'hFF);
      wr(3'd4, 8'h00);
      wait3();
      chk($sformatf("R8 idle row %0d", k), {7'd0, irq_o}, 8'd0);
    end

    // R5: pulse while disabled
    cpu_ie_i = 1'b0;
    req_i = 16'h0020;
    wait3();
    chk("R5 gated", {7'd0, irq_o}, 8'd0);
    req_i = '0;
    wait3();
    cpu_ie_i = 1'b1;
    tick();
    chk("R5 no latch", {7'd0, irq_o}, 8'd0);

    // R6/R7: line 3 in service, line 5 pulses before EOI
    req_i = 16'h0008;
    wait3();
    ack();
    chk("R6 vec3", vec_o, 8'h23);
    req_i = 16'h0028;
    wait3();
    chk("R6 lower blocked", {7'd0, irq_o}, 8'd0);
    req_i = 16'h0008;
    wait3();
    req_i = '0;
    wait3();
    wr(3'd4, 8'h00);
    wait3();
    chk("R7 dropped request", {7'd0, irq_o}, 8'd0);

    // R8: nested 3 then 1, secondary request between them
    req_i = 16'h0008;
    wait3();
    ack();
    req_i = 16'h000A;
    wait3();
    chk("R6 higher preempts", {7'd0, irq_o}, 8'd1);
    ack();
    chk("R6 vec1", vec_o, 8'h21);
    req_i = 16'h0100;
    wait3();
    chk("R8 line8 blocked by 1", {7'd0, irq_o}, 8'd0);
    wr(3'd4, 8'h00);
    wait3();
    chk("R8 highest cleared", {7'd0, irq_o}, 8'd1);
    ack();
    chk("R8 vec8", vec_o, 8'h70);
    req_i = '0;
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h00);
    wr(3'd4, 8'h00);
    wait3();
    chk("R8 all retired", {7'd0, irq_o}, 8'd0);

    // R9: primary lost
    ack();
    chk("R9 primary lost vec", vec_o, 8'h27);
    chk("R9 primary lost flag", {7'd0, lost_o}, 8'd1);

    // R9: secondary lost, cascade still seen
    req_i = 16'h1000;
    wait3();
    req_i = '0;
    tick();
    ack();
    chk("R9 secondary lost vec", vec_o, 8'h77);
    chk("R9 secondary lost flag", {7'd0, lost_o}, 8'd1);
    req_i = 16'h0020;
    wait3();
    chk("R9 nothing in service", {7'd0, irq_o}, 8'd1);
    ack();
    chk("R11 vec5", vec_o, 8'h25);
    chk("R11 flag clear", {7'd0, lost_o}, 8'd0);
    req_i = '0;
    wr(3'd4, 8'h00);

    // R10: mask immediate
    req_i = 16'h0010;
    wait3();
    chk("R10 before mask", {7'd0, irq_o}, 8'd1);
    wr(3'd1, 8'h10);
    chk("R10 masked now", {7'd0, irq_o}, 8'd0);
    ack();
    chk("R10 masked not acked", vec_o, 8'h27);
    wr(3'd1, 8'h00);
    chk("R10 unmasked", {7'd0, irq_o}, 8'd1);
    req_i = '0;
    wait3();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule